// File: doc/BRIEF.md
# Ten-Source Interrupt Collector

This block merges ten level-signalled interrupt sources into one request line for a host processor. Four of the sources are the summary lines of the general-purpose I/O banks; the other six come from on-chip peripherals. Every cycle the block registers the source levels into a pending word. The host reads that word through a small 16-bit register port to find out which sources need service. An all-zero pending word means there is nothing left to do.

A second register holds one enable bit per source and a master enable bit. The host request is registered. It is high while at least one enabled source is pending and the master enable is set. Every write to the enable register pulls the request low for one cycle. If work is still outstanding after the write, the host therefore sees a fresh rising edge, which is the only thing it samples.

Top module: `irq_collect`

## Requirements
- R1: Reading address 0 (status) returns, in bits 3:0, the levels of `bank_lvl` bits 0 to 3 as they stood at the previous rising clock edge.
- R2: Status bits 9:4 return the levels of `periph_lvl` bits 0 to 5 as they stood at the previous rising clock edge.
- R3: Status bits 15:10 always read as zero.
- R4: Reading address 1 (enable register) returns the per-source enables in bits 9:0 and the master enable in bit 15. Bits 14:10 read as zero.
- R5: After reset the enable register reads zero and `host_irq` is low.
- R6: When no enable-register write occurs in a cycle, `host_irq` at the next edge becomes one exactly when the master enable is set and some pending bit has its enable bit set.
- R7: While the master enable is clear, `host_irq` stays low at the next edge whatever the pending and enable bits hold.
- R8: A write to address 0 changes nothing. The status word afterwards still shows only the source levels, and the enable register is untouched.
- R9: A write to address 1 forces `host_irq` low at the next edge. One edge later the request rises again if enabled work is still pending, giving the host a new rising edge.
- R10: A status bit returns to zero one edge after its source drops, even when nobody has read it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_lvl | input | 4 | Summary interrupt levels of the four I/O banks |
| periph_lvl | input | 6 | Interrupt levels of the six peripherals |
| reg_addr | input | 1 | Register select: 0 status, 1 enable register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register, combinational |
| host_irq | output | 1 | Registered interrupt request to the host, used by its rising edge |

## Verification
The properties assume that the source levels and the register port are synchronous to `clk` and stable around each rising edge. They also assume that the master enable sits above every source bit, so bits 14:10 of the enable word are truly unused. The stimulus changes every input on the falling edge only. It draws source levels, register selects, write strobes and write data at random, so masked, unmasked, master-off and back-to-back enable writes all occur. Directed steps cover pending-while-enabled, re-writing an unchanged enable value, and dropping a source with no read in between.

// File: rtl/irq_collect_pkg.sv
package irq_collect_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int N_SRC = 10
) (
  input  logic             clk,
  input  logic             rst_s,
  input  logic [N_SRC-1:0] src_in,
  output logic [N_SRC-1:0] pend_q
);
  logic [N_SRC-1:0] pend_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_comb pend_d[i] = src_in[i];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N_SRC   = 10,
  parameter int DW      = 16,
  parameter int GEN_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_s,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic [N_SRC-1:0] en_q,
  output logic             gen_q
);
  logic [N_SRC-1:0] en_d;
  logic             gen_d;

  always_comb begin
    en_d  = en_q;
    gen_d = gen_q;
    if (wr_en) begin
      en_d  = wdata[N_SRC-1:0];
      gen_d = wdata[GEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q  <= '0;
      gen_q <= 1'b0;
    end else if (wr_en) begin
      en_q  <= en_d;
      gen_q <= gen_d;
    end
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int N_SRC = 10
) (
  input  logic             clk,
  input  logic             rst_s,
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] en,
  input  logic             gen,
  input  logic             mask_wr,
  output logic             irq_q
);
  logic             irq_d;
  logic [N_SRC-1:0] live;
  logic             any_live;

  always_comb begin
    live     = pend & en;
    any_live = |live;
    if (mask_wr) irq_d = 1'b0;
    else         irq_d = any_live & gen;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/irq_collect.sv
module irq_collect
  import irq_collect_pkg::*;
#(
  parameter int N_BANK   = 4,
  parameter int N_PERIPH = 6,
  parameter int DW       = 16,
  parameter int GEN_BIT  = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_BANK-1:0]   bank_lvl,
  input  logic [N_PERIPH-1:0] periph_lvl,
  input  logic                reg_addr,
  input  logic                reg_wr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                host_irq
);
  localparam int N_SRC = N_BANK + N_PERIPH;

  logic             rst_s;
  logic [N_SRC-1:0] src_in;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] en_q;
  logic             gen_q;
  logic             mask_wr;
  reg_sel_e         sel;

  assign src_in  = {periph_lvl, bank_lvl};
  assign sel     = reg_sel_e'(reg_addr);
  assign mask_wr = reg_wr && (sel == SEL_ENABLE);

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  irq_src_latch #(.N_SRC(N_SRC)) u_src (
    .clk    (clk),
    .rst_s  (rst_s),
    .src_in (src_in),
    .pend_q (pend_q)
  );

  irq_mask_reg #(.N_SRC(N_SRC), .DW(DW), .GEN_BIT(GEN_BIT)) u_mask (
    .clk   (clk),
    .rst_s (rst_s),
    .wr_en (mask_wr),
    .wdata (reg_wdata),
    .en_q  (en_q),
    .gen_q (gen_q)
  );

  irq_req_gen #(.N_SRC(N_SRC)) u_req (
    .clk     (clk),
    .rst_s   (rst_s),
    .pend    (pend_q),
    .en      (en_q),
    .gen     (gen_q),
    .mask_wr (mask_wr),
    .irq_q   (host_irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_STATUS: reg_rdata[N_SRC-1:0] = pend_q;
      SEL_ENABLE: begin
        reg_rdata[N_SRC-1:0] = en_q;
        reg_rdata[GEN_BIT]   = gen_q;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_collect_chk.sv
module irq_collect_chk #(
  parameter int N_SRC   = 10,
  parameter int DW      = 16,
  parameter int GEN_BIT = 15
) (
  input logic             clk,
  input logic             rst_s,
  input logic [N_SRC-1:0] src_in,
  input logic             reg_addr,
  input logic             reg_wr,
  input logic [DW-1:0]    reg_rdata,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] en_q,
  input logic             gen_q,
  input logic             host_irq
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R1 R2 R10
  pend_track_chk: assert property (@(posedge clk) disable iff (!rst_s)
    seen_q |-> (pend_q == $past(src_in)));

  // R3
  status_pad_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !reg_addr |-> (reg_rdata[DW-1:N_SRC] == '0));

  // R4
  enable_pad_chk: assert property (@(posedge clk) disable iff (!rst_s)
    reg_addr |-> (reg_rdata[GEN_BIT-1:N_SRC] == '0));

  // R6
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ((|(pend_q & en_q)) && gen_q && !(reg_wr && reg_addr)) |=> host_irq);

  // R7
  master_off_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !gen_q |=> !host_irq);

  // R9
  rearm_gap_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_wr && reg_addr) |=> !host_irq);
endmodule

bind irq_collect irq_collect_chk #(
  .N_SRC   (N_BANK + N_PERIPH),
  .DW      (DW),
  .GEN_BIT (GEN_BIT)
) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .src_in    ({periph_lvl, bank_lvl}),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .pend_q    (pend_q),
  .en_q      (en_q),
  .gen_q     (gen_q),
  .host_irq  (host_irq)
);

// File: tb/irq_collect_tb.sv
module irq_collect_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bank_lvl;
  logic [5:0]  periph_lvl;
  logic        reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        host_irq;

  int ntot = 0;
  int nbad = 0;

  logic [9:0] m_pend = '0;
  logic [9:0] m_en   = '0;
  logic       m_gen  = 1'b0;
  logic       m_irq  = 1'b0;

  always #5 clk = ~clk;

  irq_collect u_dut (
    .clk(clk), .rst_n(rst_n), .bank_lvl(bank_lvl), .periph_lvl(periph_lvl),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic a);
    if (a) return {m_gen, 5'b0, m_en};
    else   return {6'b0, m_pend};
  endfunction

  task automatic step(input logic [3:0] b, input logic [5:0] p, input logic a,
                      input logic w, input logic [15:0] d);
    logic  mw;
    string itag;
    @(negedge clk);
    bank_lvl = b; periph_lvl = p; reg_addr = a; reg_wr = w; reg_wdata = d;
    @(posedge clk);
    mw = w && a;
    if (mw)        itag = "R9";
    else if (!m_gen) itag = "R7";
    else           itag = "R6";
    m_irq  = mw ? 1'b0 : ((|(m_pend & m_en)) && m_gen);
    m_pend = {p, b};
    if (mw) begin
      m_en  = d[9:0];
      m_gen = d[15];
    end
    #1;
    chk(itag, {15'b0, host_irq}, {15'b0, m_irq});
    chk(a ? "R4" : "R1 R2 R3", reg_rdata, exp_read(a));
  endtask

  initial begin
    #2_000_000;
    ntot++; nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; bank_lvl = '0; periph_lvl = '0;
    reg_addr = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R5 reset state
    chk("R5", {15'b0, host_irq}, 16'h0000);
    step(4'h0, 6'h00, 1'b1, 1'b0, 16'h0);
    chk("R5", reg_rdata, 16'h0000);

    // R1 bank bits, R2 peripheral bits
    step(4'b0101, 6'b000000, 1'b0, 1'b0, 16'h0);
    chk("R1", reg_rdata, 16'h0005);
    step(4'b0000, 6'b100001, 1'b0, 1'b0, 16'h0);
    chk("R2", reg_rdata, 16'h0210);

    // R8 status write ignored
    step(4'b0010, 6'b0, 1'b0, 1'b1, 16'hFFFF);
    chk("R8", reg_rdata, 16'h0002);
    step(4'b0010, 6'b0, 1'b1, 1'b0, 16'h0);
    chk("R8", reg_rdata, 16'h0000);
    chk("R8", {15'b0, host_irq}, 16'h0000);

    // R6 enable bank 1 with master enable
    step(4'b0010, 6'b0, 1'b1, 1'b1, 16'h8002);
    chk("R9", {15'b0, host_irq}, 16'h0000);
    step(4'b0010, 6'b0, 1'b0, 1'b0, 16'h0);
    chk("R6", {15'b0, host_irq}, 16'h0001);
    // R9 rewrite of same value produces a gap then a new rise
    step(4'b0010, 6'b0, 1'b1, 1'b1, 16'h8002);
    chk("R9", {15'b0, host_irq}, 16'h0000);
    step(4'b0010, 6'b0, 1'b0, 1'b0, 16'h0);
    chk("R9", {15'b0, host_irq}, 16'h0001);

    // R10 source drops without a read
    step(4'b0000, 6'b0, 1'b1, 1'b0, 16'h0);
    step(4'b0000, 6'b0, 1'b0, 1'b0, 16'h0);
    chk("R10", reg_rdata, 16'h0000);
    chk("R10", {15'b0, host_irq}, 16'h0000);

    // R7 master enable off with pending enabled sources
    step(4'b0000, 6'b0, 1'b1, 1'b1, 16'h03FF);
    step(4'b1111, 6'h3F, 1'b0, 1'b0, 16'h0);
    step(4'b1111, 6'h3F, 1'b0, 1'b0, 16'h0);
    chk("R7", {15'b0, host_irq}, 16'h0000);
    chk("R3", reg_rdata & 16'hFC00, 16'h0000);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0], r[9:4], r[10], (r[13:11] == 3'd0), $urandom);
    end

    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule